// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block sits on the host side of a bidirectional parallel port. It runs the byte-wide address and data handshakes of the enhanced parallel port. It owns the port's control register and the sticky handshake-timeout flag. It also serves reads of the status register, with bit 0 replaced by that flag. A host access to offset 3 becomes an address cycle and an access to offset 4 becomes a data cycle. A cycle starts only when the control register holds the exact pattern required for the chosen direction. A 16-bit or 32-bit access to the data offset runs as two or four byte cycles, lowest byte first.

Each byte cycle pulls one strobe low and waits for the peripheral to raise its wait line. On a write, the cycle also pulls the write line low and drives the data bus. The cycle then releases the strobe and waits for the wait line to fall. A programmable cycle counter watches both waits. If it expires, the cycle is aborted, the timeout flag is set and the remaining bytes of the access are dropped. The host is held off with `busy` from the accepted request until the one-cycle `ready` pulse.

Top module: `epp_cycle_engine`

## Requirements
- R1: Offset 3 runs cycles on the address strobe and offset 4 runs cycles on the data strobe; the two strobes are never low together.
- R2: A write to offset 3 or 4 starts a cycle only when control AND 0x2F equals 0x04. Otherwise the write produces no strobe and no byte at the peripheral.
- R3: A read of offset 3 or 4 starts a cycle only when control AND 0x2F equals 0x24. Otherwise it returns all ones in the active byte lanes: lane 0 for a byte access, lanes 0-1 for size 1, lanes 0-3 for size 2. Unused lanes read zero.
- R4: During a byte cycle the strobe stays low until `epp_wait_i` is high. It is released on the next edge after that. The cycle completes once `epp_wait_i` is low again. On a write, `epp_write_n` is low and the bus is driven for the whole cycle. On a read, the byte is sampled while the strobe is low and the wait line is high.
- R5: If `epp_wait_i` does not respond within TIMEOUT_CYCLES cycles, the byte cycle aborts and the timeout flag is set. No further byte of that access is run, and lanes not yet read return 0xFF.
- R6: A read of status (offset 1) returns `sts_in` bits 7..1, with bit 0 equal to the timeout flag.
- R7: The timeout flag is sticky. Only a status write with bit 0 set clears it; a status write with bit 0 clear leaves it set.
- R8: At offset 4, size 1 moves 2 bytes and size 2 moves 4 bytes, in little-endian order with lane 0 first. Offset 3 always moves one byte.
- R9: Control resets to 0x0C. A control write (offset 2) stores the value with bits 7 and 6 forced to 1. Reading offset 2 returns the stored value, and `ctrl_o` always shows it.
- R10: `busy` is high from the edge that accepts a cycle-starting request until `ready` pulses for exactly one cycle. Register accesses give `ready` on the edge after acceptance, without raising `busy`.
- R11: Reads of offsets 0, 5, 6 and 7 return 0xFF. Writes to them change no register and produce no peripheral activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request pulse, accepted when `busy` is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Register offset in the port |
| host_size | input | 2 | 0 byte, 1 half word, 2 or 3 word |
| host_wdata | input | 32 | Write data, lane 0 in bits 7..0 |
| host_rdata | output | 32 | Read data, valid with `ready` |
| busy | output | 1 | Byte cycles in progress |
| ready | output | 1 | One-cycle completion pulse |
| sts_in | input | 8 | Status lines from the port |
| ctrl_o | output | 8 | Current control register |
| epp_addr_strb_n | output | 1 | Active-low address strobe |
| epp_data_strb_n | output | 1 | Active-low data strobe |
| epp_write_n | output | 1 | Active-low write line |
| epp_dout | output | 8 | Data bus out |
| epp_doe | output | 1 | Data bus drive enable |
| epp_din | input | 8 | Data bus in |
| epp_wait_i | input | 1 | Peripheral wait line |

## Verification
The assertions assume that `epp_wait_i` and `epp_din` are synchronous to `clk`. They also assume the host raises `host_req` only while `busy` is low. The bench meets both conditions. Its peripheral model changes the wait line and the data bus only on clock edges. Its access task pulses the request for one cycle and then waits for `ready` before the next request. The peripheral model can be given a byte budget, after which it stops answering; this is how aborts are provoked, including one partway through a wide access.

// File: rtl/epp_pkg.sv
// Package: shared constants and types of the parallel port cycle engine.
// Assumes a 32-bit host data path split into four byte lanes.
package epp_pkg;
    localparam int HOST_W    = 32;
    localparam int LANES     = HOST_W / 8;
    localparam int LANE_IW   = $clog2(LANES);

    localparam logic [2:0] OFF_STATUS = 3'd1;
    localparam logic [2:0] OFF_CTRL   = 3'd2;
    localparam logic [2:0] OFF_ADDR   = 3'd3;
    localparam logic [2:0] OFF_DATA   = 3'd4;

    localparam logic [7:0] CTRL_RESET = 8'h0C;
    localparam logic [7:0] CTRL_FORCE = 8'hC0;
    localparam logic [7:0] PERM_MASK  = 8'h2F;
    localparam logic [7:0] PERM_WRITE = 8'h04;
    localparam logic [7:0] PERM_READ  = 8'h24;

    typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_RELEASE} phase_t;
endpackage

// File: rtl/epp_byte_cycle.sv
// Module: runs one byte handshake on the address or data strobe.
// Assumes start is a one-cycle pulse issued only while idle, and that the
// wait line is synchronous to clk. done pulses once per cycle; err goes with
// done when the wait counter expires.
module epp_byte_cycle
    import epp_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_write,
    input  logic       is_addr,
    input  logic [7:0] wbyte,
    output logic       done,
    output logic       err,
    output logic [7:0] rbyte,
    output logic       addr_strb_n,
    output logic       data_strb_n,
    output logic       write_n,
    output logic [7:0] dout,
    output logic       doe,
    input  logic [7:0] din,
    input  logic       wait_i
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    phase_t        phase_q;
    logic [CW-1:0] cnt_q;
    logic          wr_q, ad_q;
    logic [7:0]    wd_q;

    // Handshake sequencer with a per-phase wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            ad_q    <= 1'b0;
            wd_q    <= 8'h00;
            rbyte   <= 8'h00;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= '0;
                        wr_q    <= is_write;
                        ad_q    <= is_addr;
                        wd_q    <= wbyte;
                    end
                end
                PH_STROBE: begin
                    if (wait_i) begin
                        rbyte   <= din;
                        phase_q <= PH_RELEASE;
                        cnt_q   <= '0;
                    end else if (cnt_q == LAST) begin
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                        err     <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_RELEASE: begin
                    if (!wait_i) begin
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                    end else if (cnt_q == LAST) begin
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                        err     <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the phase.
    always_comb begin
        addr_strb_n = !((phase_q == PH_STROBE) && ad_q);
        data_strb_n = !((phase_q == PH_STROBE) && !ad_q);
        write_n     = !(wr_q && (phase_q != PH_IDLE));
        doe         = wr_q && (phase_q != PH_IDLE);
        dout        = wd_q;
    end

    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strb_n || data_strb_n);
    assert_release_on_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(addr_strb_n && data_strb_n) && wait_i) |=> (addr_strb_n && data_strb_n));
    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/epp_regs.sv
// Module: control register and sticky timeout flag.
// Assumes ctrl_we and sts_clr are single-cycle strobes from the sequencer.
module epp_regs
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       sts_clr,
    input  logic       set_timeout,
    input  logic [7:0] sts_in,
    output logic [7:0] ctrl_q,
    output logic [7:0] status_rd
);
    logic timeout_q;

    // Control register with the two top bits forced on write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (ctrl_we) ctrl_q <= ctrl_wdata | CTRL_FORCE;
    end

    // Sticky flag: a handshake failure sets it, a status write of bit 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)           timeout_q <= 1'b0;
        else if (set_timeout) timeout_q <= 1'b1;
        else if (sts_clr)     timeout_q <= 1'b0;
    end

    // Status view with bit 0 taken from the flag.
    always_comb status_rd = (sts_in & 8'hFE) | {7'b0, timeout_q};

    assert_ctrl_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_q[7:6] == 2'b11));
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_timeout |=> timeout_q);
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_q && !sts_clr) |=> timeout_q);
endmodule

// File: rtl/epp_host_seq.sv
// Module: decodes host requests, checks cycle permission and splits wide
// data accesses into little-endian byte cycles.
// Assumes host_req is raised only while busy is low.
module epp_host_seq
    import epp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_off,
    input  logic [1:0]        host_size,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              busy,
    output logic              ready,
    input  logic [7:0]        ctrl_q,
    input  logic [7:0]        status_rd,
    output logic              ctrl_we,
    output logic              sts_clr,
    output logic              byte_start,
    output logic              byte_is_write,
    output logic              byte_is_addr,
    output logic [7:0]        byte_wdata,
    input  logic              byte_done,
    input  logic              byte_err,
    input  logic [7:0]        byte_rdata
);
    logic               accept, is_epp, perm;
    logic [LANE_IW-1:0] nlast;
    logic [HOST_W-1:0]  lane_mask, wbuf_q;
    logic [LANE_IW-1:0] idx_q, last_q;

    // Request decode: permission, byte count and active lanes.
    always_comb begin
        accept  = host_req && !busy;
        is_epp  = (host_off == OFF_ADDR) || (host_off == OFF_DATA);
        perm    = host_we ? ((ctrl_q & PERM_MASK) == PERM_WRITE)
                          : ((ctrl_q & PERM_MASK) == PERM_READ);
        nlast   = '0;
        if (host_off == OFF_DATA) begin
            case (host_size)
                2'd0:    nlast = LANE_IW'(0);
                2'd1:    nlast = LANE_IW'(1);
                default: nlast = LANE_IW'(LANES - 1);
            endcase
        end
        lane_mask = '0;
        for (int i = 0; i < LANES; i++)
            if (LANE_IW'(i) <= nlast) lane_mask[i*8 +: 8] = 8'hFF;
        ctrl_we = accept && host_we && (host_off == OFF_CTRL);
        sts_clr = accept && host_we && (host_off == OFF_STATUS) && host_wdata[0];
    end

    // Access sequencer: immediate register replies or a run of byte cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy          <= 1'b0;
            ready         <= 1'b0;
            host_rdata    <= '0;
            byte_start    <= 1'b0;
            byte_is_write <= 1'b0;
            byte_is_addr  <= 1'b0;
            wbuf_q        <= '0;
            idx_q         <= '0;
            last_q        <= '0;
        end else begin
            ready      <= 1'b0;
            byte_start <= 1'b0;
            if (accept) begin
                if (is_epp && perm) begin
                    busy          <= 1'b1;
                    byte_start    <= 1'b1;
                    byte_is_write <= host_we;
                    byte_is_addr  <= (host_off == OFF_ADDR);
                    wbuf_q        <= host_wdata;
                    idx_q         <= '0;
                    last_q        <= nlast;
                    host_rdata    <= host_we ? '0 : lane_mask;
                end else begin
                    ready <= 1'b1;
                    if (host_we)                      host_rdata <= '0;
                    else if (host_off == OFF_STATUS)  host_rdata <= {24'h0, status_rd};
                    else if (host_off == OFF_CTRL)    host_rdata <= {24'h0, ctrl_q};
                    else if (is_epp)                  host_rdata <= lane_mask;
                    else                              host_rdata <= {24'h0, 8'hFF};
                end
            end else if (busy && byte_done) begin
                if (!byte_is_write && !byte_err)
                    host_rdata[{idx_q, 3'b000} +: 8] <= byte_rdata;
                if (byte_err || (idx_q == last_q)) begin
                    busy  <= 1'b0;
                    ready <= 1'b1;
                end else begin
                    idx_q      <= idx_q + 1'b1;
                    byte_start <= 1'b1;
                end
            end
        end
    end

    // Byte lane presented to the current cycle.
    always_comb byte_wdata = wbuf_q[{idx_q, 3'b000} +: 8];

    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    assert_start_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start |-> busy);
endmodule

// File: rtl/epp_cycle_engine.sv
// Module: top of the enhanced parallel port cycle engine.
// Assumes pins are synchronous to clk; TIMEOUT_CYCLES is the wait limit
// in clock cycles (1000 = 10 us at 100 MHz).
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [2:0]  host_off,
    input  logic [1:0]  host_size,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        busy,
    output logic        ready,
    input  logic [7:0]  sts_in,
    output logic [7:0]  ctrl_o,
    output logic        epp_addr_strb_n,
    output logic        epp_data_strb_n,
    output logic        epp_write_n,
    output logic [7:0]  epp_dout,
    output logic        epp_doe,
    input  logic [7:0]  epp_din,
    input  logic        epp_wait_i
);
    logic       ctrl_we, sts_clr;
    logic [7:0] ctrl_q, status_rd;
    logic       b_start, b_wr, b_ad, b_done, b_err;
    logic [7:0] b_wd, b_rd;

    epp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(host_wdata[7:0]),
        .sts_clr(sts_clr), .set_timeout(b_err), .sts_in(sts_in),
        .ctrl_q(ctrl_q), .status_rd(status_rd)
    );

    epp_host_seq u_seq (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .ready(ready),
        .ctrl_q(ctrl_q), .status_rd(status_rd), .ctrl_we(ctrl_we), .sts_clr(sts_clr),
        .byte_start(b_start), .byte_is_write(b_wr), .byte_is_addr(b_ad),
        .byte_wdata(b_wd), .byte_done(b_done), .byte_err(b_err), .byte_rdata(b_rd)
    );

    epp_byte_cycle #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_byte (
        .clk(clk), .rst_n(rst_n), .start(b_start), .is_write(b_wr), .is_addr(b_ad),
        .wbyte(b_wd), .done(b_done), .err(b_err), .rbyte(b_rd),
        .addr_strb_n(epp_addr_strb_n), .data_strb_n(epp_data_strb_n),
        .write_n(epp_write_n), .dout(epp_dout), .doe(epp_doe),
        .din(epp_din), .wait_i(epp_wait_i)
    );

    assign ctrl_o = ctrl_q;

    assert_err_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        b_err |-> busy);
endmodule

// File: tb/tb_epp_cycle_engine.sv
module tb_epp_cycle_engine;
    localparam int TO = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [2:0]  host_off = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        busy, ready;
    logic [7:0]  sts_in = 8'h5B, ctrl_o;
    logic        epp_addr_strb_n, epp_data_strb_n, epp_write_n, epp_doe, epp_wait_i;
    logic [7:0]  epp_dout, epp_din;

    int checks = 0, errors = 0;

    // peripheral model
    int       served = 0, budget = 1000, wcount = 0, rcount = 0;
    logic     pend_rd = 1'b0, srv = 1'b0, pwait = 1'b0;
    logic [7:0] wlog [0:63];
    logic       alog [0:63];
    wire      strb_low = !epp_addr_strb_n || !epp_data_strb_n;
    assign epp_wait_i = pwait;
    assign epp_din = epp_addr_strb_n ? (8'h30 + 8'(rcount)) : 8'hA5;

    epp_cycle_engine #(.TIMEOUT_CYCLES(TO)) dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (strb_low && !pwait && !srv && served < budget) begin
            pwait  <= 1'b1;
            srv    <= 1'b1;
            served <= served + 1;
            if (!epp_write_n) begin
                wlog[wcount[5:0]] <= epp_dout;
                alog[wcount[5:0]] <= !epp_addr_strb_n;
                wcount <= wcount + 1;
                pend_rd <= 1'b0;
            end else pend_rd <= epp_addr_strb_n;
        end
        if (!strb_low) begin
            srv <= 1'b0;
            if (pwait) begin
                pwait <= 1'b0;
                if (pend_rd) rcount <= rcount + 1;
                pend_rd <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [2:0] off, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_off = off; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        while (!ready && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) begin errors++; checks++; $display("FAIL R10: ready never seen"); end
        rd = host_rdata;
    endtask

    // {chk, we, off, size, wdata, exp}
    localparam logic [70:0] VEC [0:8] = '{
        {1'b0, 1'b1, 3'd2, 2'd0, 32'h0000_0000, 32'h0},
        {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,         32'h0000_00C0},   // R9
        {1'b1, 1'b0, 3'd4, 2'd2, 32'h0,         32'hFFFF_FFFF},   // R3
        {1'b1, 1'b0, 3'd3, 2'd0, 32'h0,         32'h0000_00FF},   // R3
        {1'b1, 1'b0, 3'd4, 2'd1, 32'h0,         32'h0000_FFFF},   // R3
        {1'b0, 1'b1, 3'd2, 2'd0, 32'h0000_0024, 32'h0},
        {1'b1, 1'b0, 3'd2, 2'd0, 32'h0,         32'h0000_00E4},   // R9
        {1'b1, 1'b0, 3'd1, 2'd0, 32'h0,         32'h0000_005A},   // R6
        {1'b1, 1'b0, 3'd5, 2'd0, 32'h0,         32'h0000_00FF}    // R11
    };

    initial begin : wd
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ctrl", {24'h0, ctrl_o}, 32'h0C);
        chk("R10 reset busy/ready", {30'h0, busy, ready}, 32'h0);
        chk("R4 reset pins", {28'h0, epp_addr_strb_n, epp_data_strb_n, epp_write_n, epp_doe}, 32'hE);

        for (int i = 0; i < 9; i++) begin
            access(VEC[i][69], VEC[i][68:66], VEC[i][65:64], VEC[i][63:32], r);
            if (VEC[i][70]) chk($sformatf("R3/R6/R9/R11 vector %0d", i), r, VEC[i][31:0]);
        end

        // R2: writes ignored under read configuration, R11 offset 6
        w0 = wcount;
        access(1'b1, 3'd4, 2'd0, 32'h77, r);
        access(1'b1, 3'd3, 2'd0, 32'h78, r);
        access(1'b1, 3'd6, 2'd0, 32'h79, r);
        chk("R2 denied writes reach no peripheral", 32'(wcount - w0), 32'h0);
        access(1'b0, 3'd2, 2'd0, 32'h0, r);
        chk("R11 offset 6 write leaves ctrl", r, 32'hE4);

        // R1/R2/R4: address write, then R8 word data write
        access(1'b1, 3'd2, 2'd0, 32'h04, r);
        w0 = wcount;
        access(1'b1, 3'd3, 2'd0, 32'h3C, r);
        chk("R1 R2 address byte", {23'h0, alog[w0], wlog[w0]}, {23'h0, 1'b1, 8'h3C});
        access(1'b1, 3'd4, 2'd2, 32'hDDCC_BBAA, r);
        chk("R8 four bytes written", 32'(wcount - w0), 32'd5);
        chk("R8 byte order", {wlog[w0+1], wlog[w0+2], wlog[w0+3], wlog[w0+4]}, 32'hAABB_CCDD);
        chk("R1 data strobe used", {31'h0, alog[w0+1]}, 32'h0);
        access(1'b1, 3'd4, 2'd1, 32'h0000_2211, r);
        chk("R8 half word order", {16'h0, wlog[w0+5], wlog[w0+6]}, 32'h1122);

        // R3/R4/R8 reads
        access(1'b1, 3'd2, 2'd0, 32'h24, r);
        w0 = rcount;
        access(1'b0, 3'd4, 2'd2, 32'h0, r);
        chk("R8 R4 word read", r, {8'(8'h33 + w0), 8'(8'h32 + w0), 8'(8'h31 + w0), 8'(8'h30 + w0)});
        access(1'b0, 3'd3, 2'd0, 32'h0, r);
        chk("R1 R3 address read", r, 32'hA5);
        access(1'b0, 3'd1, 2'd0, 32'h0, r);
        chk("R6 no timeout yet", r, 32'h5A);

        // R5: partial abort on a half-word read (one byte answered)
        budget = served + 1;
        w0 = rcount;
        access(1'b0, 3'd4, 2'd1, 32'h0, r);
        chk("R5 partial read lanes", r, {16'h0, 8'hFF, 8'(8'h30 + w0)});
        access(1'b0, 3'd1, 2'd0, 32'h0, r);
        chk("R5 R6 timeout in status", r, 32'h5B);

        // R5: abort mid word write drops remaining bytes
        access(1'b1, 3'd2, 2'd0, 32'h04, r);
        budget = served + 2;
        w0 = wcount;
        access(1'b1, 3'd4, 2'd2, 32'h4433_2211, r);
        chk("R5 remaining bytes dropped", 32'(wcount - w0), 32'd2);
        budget = 100000;
        access(1'b1, 3'd3, 2'd0, 32'h01, r);

        // R7 sticky and clear
        access(1'b0, 3'd1, 2'd0, 32'h0, r);
        chk("R7 flag survives good cycle", r, 32'h5B);
        access(1'b1, 3'd1, 2'd0, 32'hFE, r);
        access(1'b0, 3'd1, 2'd0, 32'h0, r);
        chk("R7 bit0 clear write keeps flag", r, 32'h5B);
        access(1'b1, 3'd1, 2'd0, 32'h01, r);
        access(1'b0, 3'd1, 2'd0, 32'h0, r);
        chk("R7 flag cleared", r, 32'h5A);

        // R10: busy high right after a cycle-starting request
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_off = 3'd3; host_wdata = 32'h55;
        @(negedge clk);
        host_req = 1'b0;
        chk("R10 busy during cycle", {31'h0, busy}, 32'h1);
        while (!ready) @(negedge clk);
        @(negedge clk);
        chk("R10 ready single pulse", {30'h0, busy, ready}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule